// File: doc/BRIEF.md
# Nibble-Addressed DAC Write Sequencer

This block is a bus master that turns a 10-bit converter code, offered on a valid/ready request port, into the sequence of chip-select, write, address, data and load strobes that a double-buffered, nibble-addressed parallel DAC interface expects. The code is widened to 12 bits with two zero sub-LSB bits, split into nibbles or a byte-plus-nibble, and written one latch at a time. After the writes, the block either pulses the load strobe or relies on a load line held low, which makes the converter latch transparent.

Two static choices set the bus width. A narrow 4-bit bus takes three write cycles, and an 8-bit bus takes two. A signed option converts a two's-complement sample to offset binary by flipping the code MSB, so that code 512 is the bipolar zero and code 0 is negative full scale. Every minimum time (address setup, write width, data setup, address hold, load width, and the hold that keeps load low after a write rises) is given in nanoseconds and rounded up to whole clock cycles.

Top module: `dac_write_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0, and bus_cs_n, bus_wr_n and bus_load_n are all 1.
- R2: The request code is widened to a 12-bit word {code, 2'b00}. The two appended sub-LSB bits are always written as zero.
- R3: In narrow mode (wide_bus=0) with pulsed load, there are three writes in this order: address 2'b11 with data {4'b0, word[11:8]}, then address 2'b01 with {4'b0, word[7:4]}, then address 2'b10 with {4'b0, word[3:0]}.
- R4: In wide mode (wide_bus=1), address 2'b00 carries word[7:0] and is written first. Address 2'b11 carries {4'b0, word[11:8]} and is written second.
- R5: With hold_load=1, bus_load_n stays low from acceptance onward. In narrow mode the order becomes 2'b10, then 2'b01, then 2'b11, so that the low and middle latches are written before the high one.
- R6: With signed_code=1, bit 9 of the code is inverted before widening. For example, 10'h200 is written as 0 and 10'h3FF is written as 10'h1FF.
- R7: Around each write, address and data are stable with bus_cs_n low for at least one cycle before bus_wr_n falls. bus_wr_n stays low for exactly WR_CYC cycles, which is 3 by default, and bus_wr_n is low only while bus_cs_n is low.
- R8: With pulsed load, bus_load_n goes low only after the final write has finished, stays low for exactly LOAD_CYC cycles (3 by default), and rises in the cycle in which done pulses.
- R9: With held load, done comes no earlier than TAIL_CYC cycles (3 by default) after the final rise of bus_wr_n. bus_load_n is still low at that point.
- R10: req_ready is low from acceptance until the sequence completes. done is a one-cycle pulse in the cycle in which req_ready returns high, and a waiting request is accepted in that same cycle.
- R11: wide_bus, signed_code, hold_load and the code are captured at acceptance. Changing them during a sequence has no effect on that sequence's writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_code | input | 10 | Converter code |
| wide_bus | input | 1 | 1 = 8-bit bus (two writes), 0 = 4-bit bus (three writes) |
| signed_code | input | 1 | 1 = code is two's complement, converted to offset binary |
| hold_load | input | 1 | 1 = load held low (transparent), 0 = load pulse after writes |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 2 | Latch address {A1,A0} |
| bus_data | output | 8 | Data bus |
| bus_load_n | output | 1 | Load strobe, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completion of one sequence and acceptance of the next can fall in the same cycle: done pulses as req_ready rises, and a request that is already waiting is taken at that edge. The bench provokes this by issuing a second request while the first is still running, so the driver holds req_valid high through the busy period. The scoreboard judges the result. It expects exactly one done for the first code, expects the first write of the second code to begin with a fresh chip-select setup, and expects the second sequence's byte and nibble contents in order. A second overlap occurs in pulsed mode, where the end of the load pulse coincides with done. The monitor processes the load rise before the done in that sample and checks both.

// File: rtl/dac_write_seq.sv
module dac_write_seq #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_SETUP_NS = 5,
  parameter int ADDR_HOLD_NS  = 5,
  parameter int DATA_SETUP_NS = 45,
  parameter int WR_LOW_NS     = 45,
  parameter int LOAD_LOW_NS   = 45,
  parameter int LOAD_TAIL_NS  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [9:0] req_code,
  input  logic       wide_bus,
  input  logic       signed_code,
  input  logic       hold_load,
  output logic       bus_cs_n,
  output logic       bus_wr_n,
  output logic [1:0] bus_addr,
  output logic [7:0] bus_data,
  output logic       bus_load_n,
  output logic       done
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SU_CYC   = to_cyc(ADDR_SETUP_NS);
  localparam int HOLD_CYC = to_cyc(ADDR_HOLD_NS);
  localparam int WR_CYC   = (to_cyc(WR_LOW_NS) > to_cyc(DATA_SETUP_NS)) ?
                            to_cyc(WR_LOW_NS) : to_cyc(DATA_SETUP_NS);
  localparam int LOAD_CYC = to_cyc(LOAD_LOW_NS);
  localparam int TAIL_CYC = (to_cyc(LOAD_TAIL_NS) > HOLD_CYC) ? to_cyc(LOAD_TAIL_NS) : HOLD_CYC;
  localparam int MAX_A    = (SU_CYC > WR_CYC) ? SU_CYC : WR_CYC;
  localparam int MAX_B    = (LOAD_CYC > TAIL_CYC) ? LOAD_CYC : TAIL_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WRL, S_HOLD, S_GAP, S_LOAD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, lim;
  logic [1:0]       widx;
  logic [11:0]      word_q;
  logic             wide_q, xp_q, done_q;
  logic             last, ph_end, on_bus;
  logic [1:0]       slot_addr;
  logic [7:0]       slot_data;

  assign last   = wide_q ? (widx == 2'd1) : (widx == 2'd2);
  assign ph_end = (cnt == lim - 1'b1);
  assign on_bus = (st == S_SETUP) || (st == S_WRL) || (st == S_HOLD);

  always_comb begin
    case (st)
      S_SETUP: lim = CNT_W'(SU_CYC);
      S_WRL:   lim = CNT_W'(WR_CYC);
      S_HOLD:  lim = (last && xp_q) ? CNT_W'(TAIL_CYC) : CNT_W'(HOLD_CYC);
      S_LOAD:  lim = CNT_W'(LOAD_CYC);
      default: lim = CNT_W'(1);
    endcase
  end

  always_comb begin
    slot_addr = 2'b11;
    slot_data = {4'b0, word_q[11:8]};
    if (wide_q) begin
      if (widx == 2'd0) begin
        slot_addr = 2'b00;
        slot_data = word_q[7:0];
      end
    end else begin
      case (widx)
        2'd0: if (xp_q) begin slot_addr = 2'b10; slot_data = {4'b0, word_q[3:0]}; end
        2'd1: begin slot_addr = 2'b01; slot_data = {4'b0, word_q[7:4]}; end
        default: if (!xp_q) begin slot_addr = 2'b10; slot_data = {4'b0, word_q[3:0]}; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      widx   <= '0;
      word_q <= '0;
      wide_q <= 1'b0;
      xp_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          word_q <= {req_code ^ {signed_code, 9'b0}, 2'b00};
          wide_q <= wide_bus;
          xp_q   <= hold_load;
          widx   <= '0;
          cnt    <= '0;
          st     <= S_SETUP;
        end
        S_SETUP, S_WRL, S_LOAD, S_HOLD: begin
          if (!ph_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            case (st)
              S_SETUP: st <= S_WRL;
              S_WRL:   st <= S_HOLD;
              S_HOLD: begin
                if (!last)     st <= S_GAP;
                else if (xp_q) begin st <= S_IDLE; done_q <= 1'b1; end
                else           st <= S_LOAD;
              end
              default: begin st <= S_IDLE; done_q <= 1'b1; end
            endcase
          end
        end
        S_GAP: begin
          widx <= widx + 1'b1;
          st   <= S_SETUP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign done       = done_q;
  assign bus_cs_n   = !on_bus;
  assign bus_wr_n   = (st != S_WRL);
  assign bus_addr   = on_bus ? slot_addr : 2'b00;
  assign bus_data   = on_bus ? slot_data : 8'h00;
  assign bus_load_n = !(xp_q || st == S_LOAD);

  logic [7:0] wr_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wr_low_cnt <= '0;
    else if (bus_wr_n)    wr_low_cnt <= '0;
    else if (wr_low_cnt != 8'hFF) wr_low_cnt <= wr_low_cnt + 1'b1;
  end

  assert_wr_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n) else $error("write strobe outside chip select");

  assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> ($stable(bus_addr) && $stable(bus_data) && !$past(bus_cs_n)))
    else $error("address or data moved during write");

  assert_wr_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (wr_low_cnt == 8'(WR_CYC))) else $error("write width wrong");

  assert_load_after_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_load_n && !xp_q) |-> (bus_wr_n && bus_cs_n)) else $error("load pulse overlaps write");

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready ##1 !done)) else $error("done not a single pulse with ready");

  assert_held_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && xp_q) |-> !bus_load_n) else $error("held load released while busy");

endmodule

// File: tb/dac_write_seq_bench.sv
module dac_write_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [9:0] req_code = '0;
  logic       wide_bus = 1'b0, signed_code = 1'b0, hold_load = 1'b0;
  logic       req_ready, bus_cs_n, bus_wr_n, bus_load_n, done;
  logic [1:0] bus_addr;
  logic [7:0] bus_data;

  int checks = 0;
  int errors = 0;
  logic [11:0] expq[$];

  always #10 clk = ~clk;

  dac_write_seq u_dac_write_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .wide_bus(wide_bus), .signed_code(signed_code),
    .hold_load(hold_load), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_load_n(bus_load_n), .done(done)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push_expect(input logic [9:0] code, input bit wide, input bit sgn, input bit xp);
    logic [11:0] w;
    w = {code ^ (sgn ? 10'h200 : 10'h000), 2'b00};
    if (wide) begin
      expq.push_back({2'd0, 2'b00, w[7:0]});
      expq.push_back({2'd0, 2'b11, 4'b0, w[11:8]});
    end else if (xp) begin
      expq.push_back({2'd0, 2'b10, 4'b0, w[3:0]});
      expq.push_back({2'd0, 2'b01, 4'b0, w[7:4]});
      expq.push_back({2'd0, 2'b11, 4'b0, w[11:8]});
    end else begin
      expq.push_back({2'd0, 2'b11, 4'b0, w[11:8]});
      expq.push_back({2'd0, 2'b01, 4'b0, w[7:4]});
      expq.push_back({2'd0, 2'b10, 4'b0, w[3:0]});
    end
    if (!xp) expq.push_back({2'd1, 10'd0});
    expq.push_back({2'd2, 9'd0, xp});
  endtask

  task automatic send(input logic [9:0] code, input bit wide, input bit sgn, input bit xp);
    push_expect(code, wide, sgn, xp);
    @(negedge clk);
    req_code = code; wide_bus = wide; signed_code = sgn; hold_load = xp;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit prev_wr = 1'b1, prev_ld = 1'b1, prev_done = 1'b0;
  int wr_low = 0, setup_cnt = 0, ld_low = 0, since_rise = 0;

  always @(negedge clk) begin
    logic [11:0] it;
    if (rst_n) begin
      if (prev_wr && !bus_wr_n)
        check(setup_cnt >= 1 && !bus_cs_n, "R7 setup before write fall", setup_cnt, 1);
      if (!prev_wr && bus_wr_n) begin
        check(wr_low == 3, "R7 write low width", wr_low, 3);
        check(!req_ready, "R10 ready low while busy", req_ready, 0);
        if (expq.size() == 0) check(0, "R3 R4 R5 unexpected write", bus_addr, 0);
        else begin
          it = expq.pop_front();
          check(it[11:10] == 2'd0 && bus_addr == it[9:8] && bus_data == it[7:0],
                "R2 R3 R4 R5 R6 R11 write contents {addr,data}",
                {bus_addr, bus_data}, it[9:0]);
        end
        since_rise = 0;
      end
      if (!prev_ld && bus_load_n && ld_low <= 8) begin
        check(ld_low == 3, "R8 load pulse width", ld_low, 3);
        if (expq.size() == 0) check(0, "R8 unexpected load pulse", 1, 0);
        else begin
          it = expq.pop_front();
          check(it[11:10] == 2'd1, "R8 load pulse after writes", it[11:10], 1);
        end
      end
      if (done) begin
        check(req_ready, "R10 ready with done", req_ready, 1);
        check(!prev_done, "R10 done single cycle", prev_done, 0);
        if (expq.size() == 0) check(0, "R10 unexpected done", 1, 0);
        else begin
          it = expq.pop_front();
          check(it[11:10] == 2'd2, "R10 done order", it[11:10], 2);
          if (it[0]) begin
            check(since_rise >= 3, "R9 tail after last write", since_rise, 3);
            check(!bus_load_n, "R9 load still low at done", bus_load_n, 0);
          end
        end
      end
      if (bus_cs_n) setup_cnt = 0; else if (bus_wr_n) setup_cnt++;
      wr_low = bus_wr_n ? 0 : wr_low + 1;
      ld_low = bus_load_n ? 0 : ld_low + 1;
      since_rise++;
      prev_wr = bus_wr_n; prev_ld = bus_load_n; prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !done && bus_cs_n && bus_wr_n && bus_load_n, "R1 reset state",
          {req_ready, done, bus_cs_n, bus_wr_n, bus_load_n}, 5'b10111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && bus_load_n, "R1 idle after reset", {req_ready, bus_load_n}, 2'b11);

    send(10'h2D6, 0, 0, 0); drain();          // R3
    send(10'h135, 1, 0, 0); drain();          // R4
    send(10'h3A5, 0, 0, 1); drain();          // R5 R9
    check(!bus_load_n, "R5 load stays low after held sequence", bus_load_n, 0);
    send(10'h0CB, 1, 0, 1); drain();          // R5 R9 wide
    send(10'h200, 0, 1, 0); drain();          // R6 negative full scale -> 0
    send(10'h3FF, 1, 1, 0); drain();          // R6 -1 -> 0x1FF
    send(10'h000, 0, 0, 0); drain();          // R2 extremes
    send(10'h3FF, 0, 0, 0); drain();
    send(10'h155, 0, 0, 0);                   // R10 back-to-back acceptance at done
    send(10'h2AA, 1, 0, 0);
    drain();
    send(10'h1E3, 0, 0, 1);                   // R11 inputs change mid-sequence
    req_code = 10'h000; wide_bus = 1'b1; signed_code = 1'b1; hold_load = 1'b0;
    drain();
    check(expq.size() == 0, "R10 all expected events seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule